// File: doc/BRIEF.md
# Test Mode Decoder and Pin Router

This block chooses the chip's test mode once, just after power-on reset, and then reroutes pins for that mode. It takes two active-low test straps and the level on the user reset pin. The straps are captured on the first clock edge after the block's reset is released, and the mode is held until the next reset.

For the selected mode, the block picks the clock sources for the main clock net and the real-time clock net. It drives the PLL bypass select. It turns Port A pins into test controls and decides what the PD0 pin carries. It also filters the sources that may raise a standby wake-up request.

A 6-bit divider also lives in the block. It divides the main clock by 64 and keeps running in every mode, including the oscillator test mode, where the rest of the core is frozen.

Top module: `tmode_mux`

## Requirements
- R1: While por_n is low, and until the first clock edge after it goes high, the block acts in normal mode: every test strobe is 0, pll_bypass_o is 0, main_clk_o follows pll_clk_i, rtc_clk_o follows rtc_osc_i, and pd0_o follows pd0_func_i.
- R2: On the first rising clk edge with por_n high, the block samples tst0_n, tst1_n and urst_n and fixes the mode. Later changes on these inputs have no effect until por_n goes low again.
- R3: With tst0_n=1 and tst1_n=0 (bypass mode), main_clk_o follows main_pin_i and rtc_clk_o follows rtc_pin_i. pll_bypass_o is 1 and pd0_o carries osc_en_i.
- R4: With tst0_n=0, tst1_n=1 and urst_n=1 when sampled (bus test mode), pll_bypass_o is 1 and main_clk_o follows osc_main_i. The Port A bits drive the strobes as follows: bit 0 to tst_a_o, bit 1 to tst_b_o, bit 2 to tst_fast_start_o, bit 3 to tst_clk_o, and bit 4 to tst_vid_fast_o.
- R5: In bus test mode, wake_req_o equals ext_wake_i alone, and Port A has no effect on it.
- R6: With tst0_n=0, tst1_n=1 and urst_n=0 when sampled (oscillator test mode), pll_test_sel_o follows Port A bit 5 and osc_on_o follows Port A bit 4. core_hold_o is 1, pll_bypass_o is 0, and main_clk_o follows pll_clk_i.
- R7: With tst0_n=tst1_n=1, or with tst0_n=tst1_n=0, the block is in normal mode. wake_req_o is ext_wake_i OR the OR of all Port A bits, osc_on_o follows osc_en_i, and core_hold_o is 0.
- R8: The six Port A test strobes (tst_a_o, tst_b_o, tst_fast_start_o, tst_clk_o, tst_vid_fast_o and pll_test_sel_o) are 0 in every mode other than their own.
- R9: div_o is 0 at reset. It goes high after 32 rising clk edges and low again after 64, so its period is 64 clk cycles in every mode, including oscillator test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock for the mode register and the divider |
| por_n | input | 1 | Active-low power-on reset of the block |
| tst0_n | input | 1 | Test strap 0, active low |
| tst1_n | input | 1 | Test strap 1, active low |
| urst_n | input | 1 | User reset pin level, sampled with the straps |
| porta_i | input | 8 | Port A pin inputs |
| ext_wake_i | input | 1 | External wake-up input |
| osc_main_i | input | 1 | Main oscillator output |
| pll_clk_i | input | 1 | PLL output clock |
| main_pin_i | input | 1 | Main clock pin in bypass mode |
| rtc_osc_i | input | 1 | Real-time oscillator output |
| rtc_pin_i | input | 1 | Real-time clock pin in bypass mode |
| osc_en_i | input | 1 | Internal oscillator enable |
| pd0_func_i | input | 1 | Functional PD0 output value |
| main_clk_o | output | 1 | Selected main clock source |
| rtc_clk_o | output | 1 | Selected real-time clock source |
| pll_bypass_o | output | 1 | PLL bypass select |
| pd0_o | output | 1 | PD0 pin output |
| tst_a_o | output | 1 | Bus test control A |
| tst_b_o | output | 1 | Bus test control B |
| tst_fast_start_o | output | 1 | Real-time divider fast start |
| tst_clk_o | output | 1 | Test clock insertion |
| tst_vid_fast_o | output | 1 | Video address counter speed-up |
| pll_test_sel_o | output | 1 | PLL test select |
| osc_on_o | output | 1 | Oscillator circuit enable |
| core_hold_o | output | 1 | Freezes core logic in oscillator test mode |
| wake_req_o | output | 1 | Gated standby wake-up request |
| div_o | output | 1 | Main clock divided by 64 |

## Verification
Only two results are registered, and each has a fixed latency. The mode takes effect one rising edge after por_n rises. The divider output changes on the 32nd and 64th edges after release. Everything else is combinational from the captured mode and the pins, so it is due in the same cycle.

Inputs change on falling edges, and each check samples on a later falling edge. Reset is released on a falling edge, so the edge that captures the mode is exactly half a period later. The divider checks count falling edges from that release and sample after edges 31, 32, 63 and 64.

// File: rtl/tmode_mux.sv
module tmode_mux #(
  parameter int PA_W  = 8,
  parameter int DIV_W = 6
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            tst0_n,
  input  logic            tst1_n,
  input  logic            urst_n,
  input  logic [PA_W-1:0] porta_i,
  input  logic            ext_wake_i,
  input  logic            osc_main_i,
  input  logic            pll_clk_i,
  input  logic            main_pin_i,
  input  logic            rtc_osc_i,
  input  logic            rtc_pin_i,
  input  logic            osc_en_i,
  input  logic            pd0_func_i,
  output logic            main_clk_o,
  output logic            rtc_clk_o,
  output logic            pll_bypass_o,
  output logic            pd0_o,
  output logic            tst_a_o,
  output logic            tst_b_o,
  output logic            tst_fast_start_o,
  output logic            tst_clk_o,
  output logic            tst_vid_fast_o,
  output logic            pll_test_sel_o,
  output logic            osc_on_o,
  output logic            core_hold_o,
  output logic            wake_req_o,
  output logic            div_o
);

  typedef enum logic [1:0] {M_NORM = 2'd0, M_BYP = 2'd1, M_BUS = 2'd2, M_OSC = 2'd3} mode_t;

  mode_t            mode_q;
  logic             cap_done;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q   <= M_NORM;
      cap_done <= 1'b0;
    end else if (!cap_done) begin
      cap_done <= 1'b1;
      unique case ({tst0_n, tst1_n})
        2'b10:   mode_q <= M_BYP;
        2'b01:   mode_q <= urst_n ? M_BUS : M_OSC;
        default: mode_q <= M_NORM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign div_o = cnt[DIV_W-1];

  wire is_byp = (mode_q == M_BYP);
  wire is_bus = (mode_q == M_BUS);
  wire is_osc = (mode_q == M_OSC);

  always_comb begin
    unique case (mode_q)
      M_BYP:   main_clk_o = main_pin_i;
      M_BUS:   main_clk_o = osc_main_i;
      default: main_clk_o = pll_clk_i;
    endcase
  end

  assign rtc_clk_o    = is_byp ? rtc_pin_i : rtc_osc_i;
  assign pll_bypass_o = is_byp | is_bus;
  assign pd0_o        = is_byp ? osc_en_i : pd0_func_i;

  assign tst_a_o          = is_bus & porta_i[0];
  assign tst_b_o          = is_bus & porta_i[1];
  assign tst_fast_start_o = is_bus & porta_i[2];
  assign tst_clk_o        = is_bus & porta_i[3];
  assign tst_vid_fast_o   = is_bus & porta_i[4];

  assign pll_test_sel_o = is_osc & porta_i[5];
  assign osc_on_o       = is_osc ? porta_i[4] : osc_en_i;
  assign core_hold_o    = is_osc;

  assign wake_req_o = ext_wake_i | (~is_bus & (|porta_i));

  p_mode_held_r2: assert property (@(posedge clk) disable iff (!por_n)
    (cap_done && $past(cap_done)) |-> $stable(mode_q));

  p_wake_gate_r5: assert property (@(posedge clk) disable iff (!por_n)
    (is_bus && !ext_wake_i) |-> !wake_req_o);

  p_strobe_idle_r8: assert property (@(posedge clk) disable iff (!por_n)
    !is_bus |-> !(tst_a_o | tst_b_o | tst_fast_start_o | tst_clk_o | tst_vid_fast_o));

  p_div_runs_r9: assert property (@(posedge clk) disable iff (!por_n)
    (cap_done && $past(cap_done)) |-> (cnt == DIV_W'($past(cnt) + 1'b1)));

  p_byp_pll_r3: assert property (@(posedge clk) disable iff (!por_n)
    (pd0_o != pd0_func_i) |-> pll_bypass_o);

endmodule

// File: tb/sim_tmode_mux.sv
module sim_tmode_mux;
  logic clk = 0;
  logic por_n = 0, tst0_n = 1, tst1_n = 1, urst_n = 1;
  logic [7:0] porta_i = '0;
  logic ext_wake_i = 0, osc_main_i = 0, pll_clk_i = 0, main_pin_i = 0;
  logic rtc_osc_i = 0, rtc_pin_i = 0, osc_en_i = 0, pd0_func_i = 0;
  logic main_clk_o, rtc_clk_o, pll_bypass_o, pd0_o, tst_a_o, tst_b_o;
  logic tst_fast_start_o, tst_clk_o, tst_vid_fast_o, pll_test_sel_o;
  logic osc_on_o, core_hold_o, wake_req_o, div_o;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  tmode_mux u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] strobes();
    return {tst_vid_fast_o, tst_clk_o, tst_fast_start_o, tst_b_o, tst_a_o};
  endfunction

  task automatic boot(logic s0, logic s1, logic u);
    @(negedge clk);
    por_n = 0; tst0_n = s0; tst1_n = s1; urst_n = u;
    repeat (2) @(negedge clk);
    por_n = 1;
  endtask

  task automatic t_reset_r1();
    @(negedge clk);
    por_n = 0; tst0_n = 1; tst1_n = 0; porta_i = 8'h1f;
    pll_clk_i = 1; main_pin_i = 0; rtc_osc_i = 1; rtc_pin_i = 0; pd0_func_i = 1; osc_en_i = 0;
    @(negedge clk);
    chk("R1 strobes", strobes(), 0);
    chk("R1 bypass", pll_bypass_o, 0);
    chk("R1 main", main_clk_o, 1);
    chk("R1 rtc", rtc_clk_o, 1);
    chk("R1 pd0", pd0_o, 1);
  endtask

  task automatic t_bypass_r3();
    boot(1, 0, 1);
    main_pin_i = 1; pll_clk_i = 0; rtc_pin_i = 1; rtc_osc_i = 0; osc_en_i = 1; pd0_func_i = 0;
    @(negedge clk);
    chk("R3 main", main_clk_o, 1);
    chk("R3 rtc", rtc_clk_o, 1);
    chk("R3 pll_bypass", pll_bypass_o, 1);
    chk("R3 pd0", pd0_o, 1);
    osc_en_i = 0; #1;
    chk("R3 pd0 follows", pd0_o, 0);
    tst0_n = 1; tst1_n = 1;
    repeat (3) @(negedge clk);
    osc_en_i = 1; #1;
    chk("R2 straps ignored", pd0_o, 1);
    chk("R2 still bypass", pll_bypass_o, 1);
  endtask

  task automatic t_bus_r4_r5();
    boot(0, 1, 1);
    porta_i = 8'h00; osc_main_i = 1; pll_clk_i = 0; ext_wake_i = 0;
    @(negedge clk);
    chk("R4 pll_bypass", pll_bypass_o, 1);
    chk("R4 main", main_clk_o, 1);
    porta_i = 8'h15; #1;
    chk("R4 strobes 15", strobes(), 5'h15);
    porta_i = 8'h0a; #1;
    chk("R4 strobes 0a", strobes(), 5'h0a);
    chk("R8 pll_test_sel in bus", pll_test_sel_o, 0);
    porta_i = 8'hff; #1;
    chk("R5 porta no wake", wake_req_o, 0);
    ext_wake_i = 1; #1;
    chk("R5 ext wake", wake_req_o, 1);
    ext_wake_i = 0; urst_n = 0;
    repeat (2) @(negedge clk);
    chk("R2 urst ignored", core_hold_o, 0);
  endtask

  task automatic t_osc_r6();
    boot(0, 1, 0);
    porta_i = 8'h20; pll_clk_i = 1; osc_main_i = 0; osc_en_i = 1;
    @(negedge clk);
    chk("R6 sel", pll_test_sel_o, 1);
    chk("R6 osc_on", osc_on_o, 0);
    chk("R6 hold", core_hold_o, 1);
    chk("R6 pll_bypass", pll_bypass_o, 0);
    chk("R6 main", main_clk_o, 1);
    porta_i = 8'h1f; #1;
    chk("R6 osc_on pa4", osc_on_o, 1);
    chk("R6 sel off", pll_test_sel_o, 0);
    chk("R8 bus strobes in osc", strobes(), 0);
  endtask

  task automatic t_div_r9();
    boot(0, 1, 0);
    repeat (31) @(negedge clk);
    chk("R9 div after 31", div_o, 0);
    @(negedge clk);
    chk("R9 div after 32", div_o, 1);
    repeat (31) @(negedge clk);
    chk("R9 div after 63", div_o, 1);
    @(negedge clk);
    chk("R9 div after 64", div_o, 0);
  endtask

  task automatic t_norm_r7(logic s);
    boot(s, s, 1);
    porta_i = 8'h00; ext_wake_i = 0; osc_en_i = 1;
    @(negedge clk);
    chk("R7 hold", core_hold_o, 0);
    chk("R7 osc_on", osc_on_o, 1);
    chk("R7 no wake", wake_req_o, 0);
    porta_i = 8'h80; #1;
    chk("R7 porta wake", wake_req_o, 1);
    porta_i = 8'hff; #1;
    chk("R8 strobes normal", strobes(), 0);
    chk("R8 sel normal", pll_test_sel_o, 0);
    chk("R7 pll_bypass", pll_bypass_o, 0);
  endtask

  initial begin
    t_reset_r1();
    t_bypass_r3();
    t_bus_r4_r5();
    t_osc_r6();
    t_div_r9();
    t_norm_r7(1);
    t_norm_r7(0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule